// File: doc/BRIEF.md
# Microcoded Schedule Controller

This block sequences a fixed four-step datapath schedule and drives eleven activation lines for it. A synchronous word counter is cleared by reset and loaded by a start pulse. It then advances once per clock through a constant control store. Each word it reads is turned into activation bits, and those bits are registered onto the `act` output together with the index of the step they belong to. Activation signal k (1 to 11) appears on `act[k-1]`.

The schedule is fixed. Step 0 raises signals 1, 2, 6, 8 and 10. Step 1 raises 3, 7, 9 and 11. Step 2 raises only 4, and step 3 raises only 5. A build-time parameter chooses how the store encodes this schedule:

- **Horizontal:** one wide word per step.
- **Vertical:** compact 4-bit codes. Some codes are reserved for whole groups of signals, and a step can be spread over several words.
- **Grouped:** narrow fields, each decoded on its own.

All three encodings give the same sequence of activation values. After the last step the block clears the activations, raises `done` and waits for the next start.

Top module: `mcode_sched_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, act becomes 0, step_idx becomes 0 and done becomes 0, and the block stays idle until start is sampled high.
- R2: The edge that samples start high while the block is idle loads word address 0. Each later edge consumes one store word.
- R3: Horizontal encoding (MODE=0) keeps one 11-bit word per step, and bit k-1 drives signal k directly. The four step masks are 0x2A3, 0x544, 0x008 and 0x010.
- R4: act and step_idx are loaded together on the edge that consumes the final word of a step. step_idx is the zero-based step number, and act holds its value until the next step's final word.
- R5: Vertical encoding (MODE=1) uses a 5-bit word of the form {end_of_step, code[3:0]}. The codes are decoded as follows:
  - code 0 and code 15 raise nothing;
  - codes 1 to 11 raise the single signal of that number;
  - code 12 raises the group {1,2,6,8,10};
  - code 13 raises {3,7};
  - code 14 raises {9,11}.
- R6: In vertical encoding, step 1 is stored as two words (code 13, then code 14 with end_of_step set). Their bits are merged, act does not change on the first of the two words, and the whole schedule uses five words.
- R7: Grouped encoding (MODE=2) uses five 2-bit fields, with field f in bits [2f+1:2f]. Code 0 in any field raises nothing. Codes 1, 2 and 3 of each field select the following signals:
  - field 0: signals 1, 3, 4;
  - field 1: signals 2, 7, 5;
  - field 2: signals 6, 9 (code 3 unused);
  - field 3: signals 8, 11 (code 3 unused);
  - field 4: signal 10 (codes 2 and 3 unused).
- R8: All three encodings produce the same act value for each step index.
- R9: One edge after the final word, act becomes 0 and done becomes 1. The counter then holds, and act, step_idx and done stay unchanged until start is sampled.
- R10: A start pulse sampled while a schedule is running has no effect on the sequence.
- R11: Start sampled after done clears done on that edge and replays the schedule from step 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a schedule when the block is idle |
| act | output | 11 | Registered activation signals, bit k-1 is signal k |
| step_idx | output | 2 | Step whose activations are on act |
| done | output | 1 | High after the final step until the next start |

## Verification
One instance of each encoding runs side by side from the same start pulse, and each is compared cycle by cycle against a step table. The table records how many words each step occupies. This separates the one-word-per-step encodings from the vertical one, where the two-word step must hold the previous activations for one extra cycle. The same run is then repeated in three variants:
- with a start pulse arriving in the middle of the schedule, to show it is ignored;
- after a long idle stretch following done, to show the counter holds and the replay is identical;
- after a reset asserted mid-run, to show all outputs clear.

// File: rtl/mcs_pkg.sv
// Package mcs_pkg
// Shared constants, the encoding selector and the constant-table functions
// of the schedule controller. Assumes a fixed 11-signal, 4-step schedule.
package mcs_pkg;

    localparam int NUM_SIG    = 11;
    localparam int NUM_STEP   = 4;
    localparam int STEP_W     = $clog2(NUM_STEP);
    localparam int VT_CODE_W  = $clog2(NUM_SIG);
    localparam int GRP_FIELDS = 5;
    localparam int GRP_FW     = 2;
    localparam int VT_WORDS   = 5;

    // Reserved vertical codes that raise several signals at once
    localparam int VT_GRP_A = 12;
    localparam int VT_GRP_B = 13;
    localparam int VT_GRP_C = 14;

    typedef enum logic [1:0] {
        ENC_HORIZ = 2'd0,
        ENC_VERT  = 2'd1,
        ENC_GROUP = 2'd2
    } enc_e;

    typedef logic [NUM_SIG-1:0] act_t;

    // Bit for activation signal k (1-based); 0 yields no bit
    function automatic act_t sig_bit(input int k);
        if (k >= 1 && k <= NUM_SIG) return act_t'(1) << (k - 1);
        return '0;
    endfunction

    // Activation set of each schedule step
    function automatic act_t step_mask(input int s);
        case (s)
            0:       return sig_bit(1) | sig_bit(2) | sig_bit(6) | sig_bit(8) | sig_bit(10);
            1:       return sig_bit(3) | sig_bit(7) | sig_bit(9) | sig_bit(11);
            2:       return sig_bit(4);
            3:       return sig_bit(5);
            default: return '0;
        endcase
    endfunction

    // Store word width for each encoding
    function automatic int word_width(input enc_e m);
        case (m)
            ENC_VERT:  return VT_CODE_W + 1;
            ENC_GROUP: return GRP_FIELDS * GRP_FW;
            default:   return NUM_SIG;
        endcase
    endfunction

    // Number of store words for each encoding
    function automatic int word_count(input enc_e m);
        if (m == ENC_VERT) return VT_WORDS;
        return NUM_STEP;
    endfunction

    // Expansion of one vertical code to its activation bits
    function automatic act_t vt_expand(input logic [VT_CODE_W-1:0] c);
        int ci;
        ci = int'(c);
        if (ci >= 1 && ci <= NUM_SIG) return sig_bit(ci);
        case (ci)
            VT_GRP_A: return step_mask(0);
            VT_GRP_B: return sig_bit(3) | sig_bit(7);
            VT_GRP_C: return sig_bit(9) | sig_bit(11);
            default:  return '0;
        endcase
    endfunction

    // Vertical store content: {end_of_step, code}
    function automatic logic [VT_CODE_W:0] vt_word(input int a);
        case (a)
            0:       return {1'b1, 4'(VT_GRP_A)};
            1:       return {1'b0, 4'(VT_GRP_B)};
            2:       return {1'b1, 4'(VT_GRP_C)};
            3:       return {1'b1, 4'd4};
            4:       return {1'b1, 4'd5};
            default: return '0;
        endcase
    endfunction

    // Signal selected by code c of grouped field f (0 = none)
    function automatic int grp_member(input int f, input int c);
        case (f)
            0: case (c) 1: return 1; 2: return 3; 3: return 4; default: return 0; endcase
            1: case (c) 1: return 2; 2: return 7; 3: return 5; default: return 0; endcase
            2: case (c) 1: return 6; 2: return 9; default: return 0; endcase
            3: case (c) 1: return 8; 2: return 11; default: return 0; endcase
            4: case (c) 1: return 10; default: return 0; endcase
            default: return 0;
        endcase
    endfunction

    // Grouped store content, field f in bits [2f+1:2f]
    function automatic logic [GRP_FIELDS*GRP_FW-1:0] grp_word(input int s);
        case (s)
            0:       return 10'b01_01_01_01_01;
            1:       return 10'b00_10_10_10_10;
            2:       return 10'b00_00_00_00_11;
            3:       return 10'b00_00_00_11_00;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mcs_seq.sv
// Module mcs_seq
// Word counter of the controller. Start while idle loads address 0; while
// running it advances one word per clock and stops after LAST_ADDR.
// Assumes start is a level sampled on the rising edge.
module mcs_seq #(
    parameter int ADDR_W    = 2,
    parameter int LAST_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              run,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

    // Final-word flag for the current cycle
    assign at_last = run && (addr == LAST);

    // Run flag and address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            addr <= '0;
        end else if (!run) begin
            if (start) begin
                run  <= 1'b1;
                addr <= '0;
            end
        end else if (at_last) begin
            run <= 1'b0;
        end else begin
            addr <= addr + 1'b1;
        end
    end

    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (addr <= LAST)) else $error("address past store");         // R2
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && start) |=> (run && addr == '0)) else $error("start load"); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> (!run && $stable(addr))) else $error("idle moved"); // R9

endmodule

// File: rtl/mcs_store.sv
// Module mcs_store
// Constant control store; MODE picks which encoded table is built.
// Assumes addr never exceeds the word count of the chosen encoding.
module mcs_store
    import mcs_pkg::*;
#(
    parameter enc_e MODE   = ENC_HORIZ,
    parameter int   ADDR_W = 2,
    parameter int   WORD_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);

    generate
        if (MODE == ENC_VERT) begin : g_vert
            // Compact code table, several words may form one step
            always_comb word = WORD_W'(vt_word(int'(addr)));
        end else if (MODE == ENC_GROUP) begin : g_group
            // Field-split table, one word per step
            always_comb word = WORD_W'(grp_word(int'(addr)));
        end else begin : g_horiz
            // Wide table, one bit per activation signal
            always_comb word = WORD_W'(step_mask(int'(addr)));
        end
    endgenerate

endmodule

// File: rtl/mcs_decode.sv
// Module mcs_decode
// Turns one store word into activation bits and an end-of-step flag.
// Assumes the word comes from mcs_store built with the same MODE.
module mcs_decode
    import mcs_pkg::*;
#(
    parameter enc_e MODE   = ENC_HORIZ,
    parameter int   WORD_W = 11
) (
    input  logic [WORD_W-1:0] word,
    output act_t              mask,
    output logic              eos
);

    generate
        if (MODE == ENC_VERT) begin : g_vert
            // Code expansion; top bit marks the last word of a step
            always_comb begin
                mask = vt_expand(word[VT_CODE_W-1:0]);
                eos  = word[WORD_W-1];
            end
        end else if (MODE == ENC_GROUP) begin : g_group
            act_t part [GRP_FIELDS];
            for (genvar f = 0; f < GRP_FIELDS; f++) begin : g_field
                // Independent decode of field f
                always_comb part[f] = sig_bit(grp_member(f, int'(word[f*GRP_FW +: GRP_FW])));
            end
            // Merge of field results
            always_comb begin
                mask = '0;
                for (int f = 0; f < GRP_FIELDS; f++) mask = mask | part[f];
                eos = 1'b1;
            end
        end else begin : g_horiz
            // Direct pass-through, every word ends a step
            always_comb begin
                mask = act_t'(word);
                eos  = 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/mcode_sched_ctrl.sv
// Module mcode_sched_ctrl
// Top of the microcoded schedule controller: counter, store and decoder,
// plus the accumulator and the registered activation, step and done outputs.
// Assumes start is synchronous to clk; MODE is fixed at build time.
module mcode_sched_ctrl
    import mcs_pkg::*;
#(
    parameter enc_e MODE = ENC_HORIZ
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic [NUM_SIG-1:0]    act,
    output logic [STEP_W-1:0]     step_idx,
    output logic                  done
);

    localparam int WORD_W  = word_width(MODE);
    localparam int N_WORDS = word_count(MODE);
    localparam int ADDR_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic              run;
    logic              at_last;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] word;
    act_t              dec_mask;
    logic              eos;
    act_t              acc;
    act_t              merged;
    logic [STEP_W-1:0] step_cnt;
    logic              tail;

    mcs_seq #(.ADDR_W(ADDR_W), .LAST_ADDR(N_WORDS - 1)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (run),
        .addr    (addr),
        .at_last (at_last)
    );

    mcs_store #(.MODE(MODE), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .addr (addr),
        .word (word)
    );

    mcs_decode #(.MODE(MODE), .WORD_W(WORD_W)) u_dec (
        .word (word),
        .mask (dec_mask),
        .eos  (eos)
    );

    // Bits gathered so far for the step in progress
    assign merged = acc | dec_mask;

    // Output registers, step accumulator and end-of-schedule handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= '0;
            acc      <= '0;
            step_idx <= '0;
            step_cnt <= '0;
            done     <= 1'b0;
            tail     <= 1'b0;
        end else begin
            tail <= at_last;
            if (run) begin
                if (eos) begin
                    act      <= merged;
                    acc      <= '0;
                    step_idx <= step_cnt;
                    step_cnt <= step_cnt + 1'b1;
                end else begin
                    acc <= merged;
                end
            end
            if (tail) begin
                act  <= '0;
                done <= 1'b1;
            end
            if (start && !run) begin
                done     <= 1'b0;
                acc      <= '0;
                step_cnt <= '0;
            end
        end
    end

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (act == '0)) else $error("act live while done");        // R9
    AST_MIDSTEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !eos) |=> $stable(act)) else $error("act moved mid-step"); // R6
    AST_TAIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && !start) |=> ##1 done) else $error("done missing");    // R9

endmodule

// File: tb/mcode_sched_ctrl_tb.sv
module mcode_sched_ctrl_tb;
    import mcs_pkg::*;

    localparam int CLK_P = 10;
    localparam logic [10:0] SCHED [4] = '{11'h2A3, 11'h544, 11'h008, 11'h010};
    localparam int VT_SPAN [4] = '{1, 2, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [10:0] act_h, act_v, act_g;
    logic [1:0]  st_h, st_v, st_g;
    logic        dn_h, dn_v, dn_g;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    mcode_sched_ctrl #(.MODE(ENC_HORIZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .act(act_h), .step_idx(st_h), .done(dn_h));
    mcode_sched_ctrl #(.MODE(ENC_VERT)) u_dut_vt (
        .clk(clk), .rst_n(rst_n), .start(start), .act(act_v), .step_idx(st_v), .done(dn_v));
    mcode_sched_ctrl #(.MODE(ENC_GROUP)) u_dut_gp (
        .clk(clk), .rst_n(rst_n), .start(start), .act(act_g), .step_idx(st_g), .done(dn_g));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Expected outputs c cycles after the start edge (c=0: that edge)
    function automatic void expect_at(input bit vt, input int c,
                                      output logic [10:0] a, output int st, output bit dn);
        int ends [4];
        int sum;
        sum = 0;
        for (int k = 0; k < 4; k++) begin
            sum += vt ? VT_SPAN[k] : 1;
            ends[k] = sum;
        end
        a = '0; st = -1; dn = 1'b0;
        if (c == 0) return;
        if (c > ends[3]) begin
            st = 3; dn = 1'b1;
            return;
        end
        for (int k = 0; k < 4; k++)
            if (ends[k] <= c) begin
                a = SCHED[k];
                st = k;
            end
    endfunction

    task automatic check_all(input int c, input string tag);
        logic [10:0] a;
        int st;
        bit dn;
        expect_at(1'b0, c, a, st, dn);
        chk({tag, " R3 R4 R9 hz act"}, 32'(act_h), 32'(a));
        chk({tag, " R9 hz done"}, 32'(dn_h), 32'(dn));
        if (st >= 0) chk({tag, " R4 hz step"}, 32'(st_h), 32'(st));
        chk({tag, " R7 R8 gp act"}, 32'(act_g), 32'(a));
        chk({tag, " R9 gp done"}, 32'(dn_g), 32'(dn));
        if (st >= 0) chk({tag, " R4 gp step"}, 32'(st_g), 32'(st));
        expect_at(1'b1, c, a, st, dn);
        chk({tag, " R5 R6 R8 vt act"}, 32'(act_v), 32'(a));
        chk({tag, " R9 vt done"}, 32'(dn_v), 32'(dn));
        if (st >= 0) chk({tag, " R4 vt step"}, 32'(st_v), 32'(st));
    endtask

    // One schedule run; optionally a second start pulse at cycle 2
    task automatic run_sched(input string tag, input bit mid_start);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int c = 0; c <= 8; c++) begin
            check_all(c, tag);
            if (mid_start && c == 2) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 act", 32'(act_h | act_v | act_g), 0);
        chk("R1 step", 32'(st_h | st_v | st_g), 0);
        chk("R1 done", 32'(dn_h | dn_v | dn_g), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle without start", 32'(act_h | act_v | act_g), 0);
        // R2 R3 R5 R7 R8: first run
        run_sched("run1 R2", 1'b0);
        // R9: long idle after done
        repeat (20) @(negedge clk);
        chk("R9 hold act", 32'(act_h | act_v | act_g), 0);
        chk("R9 hold done", 32'({dn_h, dn_v, dn_g}), 32'h7);
        chk("R9 hold step", 32'({st_h, st_v, st_g}), 32'h3F);
        // R10 R11: restart with an ignored mid-run start
        run_sched("run2 R10 R11", 1'b1);
        // R1: reset in the middle of a run
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 midrun act", 32'(act_h | act_v | act_g), 0);
        chk("R1 midrun step", 32'(st_h | st_v | st_g), 0);
        chk("R1 midrun done", 32'(dn_h | dn_v | dn_g), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_sched("run3 R11", 1'b0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule